// File: doc/BRIEF.md
# Beam Direction Search Sequencer

This controller runs the tag side of an uplink beam search. When the block leaves reset it raises a beacon request so that the uplink can announce the tag. While the beacon is up, every command is ignored. When the beacon ends, the controller holds a default direction and waits. Each "next" command from the downlink moves the beam one place through a grid of azimuth and elevation settings. The reader keeps sending "next" until its received signal quality peaks, and then it sends "confirm". The confirm freezes the direction and puts the block in an authentication-ready state. A later start command releases that state with a one-cycle start pulse. After that pulse the direction stays locked until the next reset.

Both the azimuth axis and the elevation axis have five settings: 0, 45, 90, 135 and 180 degrees. Setting index i stands for the angle i·45°. For each setting, the block derives the inter-element phase step for a tilt of (angle − 90°), which is sin(tilt)·360°. It rounds that step to units of 45° and registers the resulting phase code for each element of a 2×2 array. These codes drive the local-oscillator phase generator. All per-axis codes come from a constant table that is computed at elaboration.

Top module: `beam_scan_ctrl`

## Requirements
- R1: After reset is released, `beacon_req` stays high for BEACON_CYC+1 clock cycles: BEACON_CYC cycles of beacon plus one cycle for the reset synchroniser. It then falls and never rises again until the next reset. Commands presented during the beacon change neither the direction nor `auth_ready`.
- R2: During reset, and when the beacon ends, the direction is azimuth index 0 (0°) and elevation index 2 (90°).
- R3: Commands are encoded on `cmd_op` when `cmd_valid` is high: 2'b01 = next, 2'b10 = confirm, 2'b11 = start-auth, 2'b00 = none. In the search state, a next command increments `az_idx` by one at the same clock edge. When `az_idx` is 4, it instead wraps to 0 and `el_idx` increments.
- R4: A next command at (az 4, el 4) moves the direction to (0, 0). Starting from the default, 25 next commands visit all 25 grid positions exactly once and end back at the default.
- R5: The per-axis code for index i is round(−cos(i·45°)·8) mod 8, which gives codes 0, 2, 0, 6, 0. Element k has column k%2 and row k/2. Its 3-bit phase at `ant_phase[3k+2:3k]` is (column·az_code + row·el_code) mod 8, in 45° units. The phase is registered one clock after the index.
- R6: A confirm command in the search state raises `auth_ready` at that edge and freezes the direction.
- R7: In the ready state, next and confirm commands are ignored. A start-auth command produces exactly one cycle of `auth_start` and clears `auth_ready` at the same edge.
- R8: After the start pulse, all commands are ignored. The direction and the phases are held, and `auth_start` stays low.
- R9: In the search state, a start-auth command is ignored. Any opcode with `cmd_valid` low is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe from the downlink decoder |
| cmd_op | input | 2 | Command opcode (none, next, confirm, start-auth) |
| beacon_req | output | 1 | Wake-up beacon request to the uplink |
| az_idx | output | 3 | Current azimuth setting index |
| el_idx | output | 3 | Current elevation setting index |
| ant_phase | output | 12 | Four 3-bit element phase codes, element 0 in the low bits |
| auth_ready | output | 1 | Direction confirmed, waiting for the start command |
| auth_start | output | 1 | One-cycle pulse when authentication is started |

## Verification
The main stimulus is an exhaustive walk of next commands through all 25 grid positions from the default. At every step the bench checks the indices and all four element phases against codes it computes with real-valued cosines. This separates a wrong scan order, a wrong wrap point and a wrong per-axis table from one another. Commands are also sent in each state where they must be ignored: during the beacon, start-auth while searching, opcodes with the strobe low, and next or confirm after confirmation or after the start pulse. Each of these shows whether the state machine gates its inputs correctly. A mid-run reset checks that the beacon and the default direction return.

// File: rtl/beam_scan_pkg.sv
package beam_scan_pkg;

  typedef enum logic [1:0] {
    ST_BEACON = 2'd0,
    ST_SEARCH = 2'd1,
    ST_READY  = 2'd2,
    ST_LOCKED = 2'd3
  } scan_state_e;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_NEXT    = 2'd1,
    OP_CONFIRM = 2'd2,
    OP_START   = 2'd3
  } cmd_op_e;

  // Quantised inter-element phase step for a setting angle in degrees.
  // Tilt = angle - 90, step = sin(tilt)*360 = -cos(angle)*360, expressed in
  // units of 360/2^ph_bits and wrapped. Cosine uses a rational approximation
  // that is exact at 0/90/180 and within 0.2 % at 45/135.
  function automatic int axis_code(input int deg, input int ph_bits);
    int x;
    int sgn;
    int num;
    int den;
    int c_milli;
    int v;
    int r;
    int m;
    x = deg % 360;
    if (x < 0) x = x + 360;
    if (x > 180) x = 360 - x;
    sgn = 1;
    if (x > 90) begin
      x   = 180 - x;
      sgn = -1;
    end
    num     = 32400 - 4 * x * x;
    den     = 32400 + x * x;
    c_milli = sgn * ((num * 1000) / den);
    v       = -c_milli * (1 << ph_bits);
    r       = (v >= 0) ? ((v + 500) / 1000) : -((-v + 500) / 1000);
    m       = 1 << ph_bits;
    return ((r % m) + m) % m;
  endfunction

endpackage

// File: rtl/beam_rst_sync.sv
module beam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/beam_scan_fsm.sv
module beam_scan_fsm
  import beam_scan_pkg::*;
#(
  parameter int BEACON_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  output scan_state_e state_o,
  output logic        step_en_o,
  output logic        beacon_o,
  output logic        ready_o,
  output logic        start_o
);

  localparam int CNT_W = $clog2(BEACON_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BEACON_CYC - 1);

  scan_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             start_q, start_d;
  cmd_op_e          op;
  logic             is_next, is_confirm, is_start;

  assign op         = cmd_op_e'(cmd_op);
  assign is_next    = cmd_valid && (op == OP_NEXT);
  assign is_confirm = cmd_valid && (op == OP_CONFIRM);
  assign is_start   = cmd_valid && (op == OP_START);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    start_d = 1'b0;
    case (st_q)
      ST_BEACON: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) begin
          st_d  = ST_SEARCH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SEARCH: begin
        if (is_confirm) st_d = ST_READY;
      end
      ST_READY: begin
        if (is_start) begin
          st_d    = ST_LOCKED;
          start_d = 1'b1;
        end
      end
      default: begin
        st_d = st_q;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_BEACON;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o   = st_q;
  assign step_en_o = (st_q == ST_SEARCH) && is_next;
  assign beacon_o  = (st_q == ST_BEACON);
  assign ready_o   = (st_q == ST_READY);
  assign start_o   = start_q;

endmodule

// File: rtl/beam_grid_ctr.sv
module beam_grid_ctr #(
  parameter int N_AZ   = 5,
  parameter int N_EL   = 5,
  parameter int DEF_AZ = 0,
  parameter int DEF_EL = 2,
  localparam int AZ_W  = $clog2(N_AZ),
  localparam int EL_W  = $clog2(N_EL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  output logic [AZ_W-1:0] az_o,
  output logic [EL_W-1:0] el_o
);

  localparam logic [AZ_W-1:0] AZ_LAST = AZ_W'(N_AZ - 1);
  localparam logic [EL_W-1:0] EL_LAST = EL_W'(N_EL - 1);

  logic [AZ_W-1:0] az_q, az_d;
  logic [EL_W-1:0] el_q, el_d;

  // next position in row-major order, azimuth fastest
  always_comb begin
    az_d = az_q;
    el_d = el_q;
    if (az_q == AZ_LAST) begin
      az_d = '0;
      el_d = (el_q == EL_LAST) ? '0 : el_q + 1'b1;
    end else begin
      az_d = az_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      az_q <= AZ_W'(DEF_AZ);
      el_q <= EL_W'(DEF_EL);
    end else if (step_en) begin
      az_q <= az_d;
      el_q <= el_d;
    end
  end

  assign az_o = az_q;
  assign el_o = el_q;

endmodule

// File: rtl/beam_phase_map.sv
module beam_phase_map
  import beam_scan_pkg::*;
#(
  parameter int N_AZ     = 5,
  parameter int N_EL     = 5,
  parameter int STEP_DEG = 45,
  parameter int NCOL     = 2,
  parameter int NROW     = 2,
  parameter int PH_BITS  = 3,
  parameter int DEF_AZ   = 0,
  parameter int DEF_EL   = 2,
  localparam int AZ_W    = $clog2(N_AZ),
  localparam int EL_W    = $clog2(N_EL),
  localparam int N_ANT   = NCOL * NROW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AZ_W-1:0]          az_i,
  input  logic [EL_W-1:0]          el_i,
  output logic [N_ANT*PH_BITS-1:0] phase_o
);

  localparam int PH_MOD  = 1 << PH_BITS;
  localparam int RST_AZC = axis_code(DEF_AZ * STEP_DEG, PH_BITS);
  localparam int RST_ELC = axis_code(DEF_EL * STEP_DEG, PH_BITS);

  logic [PH_BITS-1:0] az_lut [N_AZ];
  logic [PH_BITS-1:0] el_lut [N_EL];
  logic [PH_BITS-1:0] az_code, el_code;

  for (genvar gi = 0; gi < N_AZ; gi++) begin : g_az_lut
    assign az_lut[gi] = PH_BITS'(axis_code(gi * STEP_DEG, PH_BITS));
  end

  for (genvar gj = 0; gj < N_EL; gj++) begin : g_el_lut
    assign el_lut[gj] = PH_BITS'(axis_code(gj * STEP_DEG, PH_BITS));
  end

  always_comb begin
    az_code = (int'(az_i) < N_AZ) ? az_lut[az_i] : '0;
    el_code = (int'(el_i) < N_EL) ? el_lut[el_i] : '0;
  end

  for (genvar ga = 0; ga < N_ANT; ga++) begin : g_ant
    localparam int COL = ga % NCOL;
    localparam int ROW = ga / NCOL;
    localparam int RST = (COL * RST_AZC + ROW * RST_ELC) % PH_MOD;

    logic [PH_BITS-1:0] ph_d, ph_q;

    always_comb begin
      ph_d = PH_BITS'(COL) * az_code + PH_BITS'(ROW) * el_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q <= PH_BITS'(RST);
      end else begin
        ph_q <= ph_d;
      end
    end

    assign phase_o[ga*PH_BITS +: PH_BITS] = ph_q;
  end

endmodule

// File: rtl/beam_scan_ctrl.sv
module beam_scan_ctrl
  import beam_scan_pkg::*;
#(
  parameter int N_AZ       = 5,
  parameter int N_EL       = 5,
  parameter int STEP_DEG   = 45,
  parameter int DEF_AZ     = 0,
  parameter int DEF_EL     = 2,
  parameter int NCOL       = 2,
  parameter int NROW       = 2,
  parameter int PH_BITS    = 3,
  parameter int BEACON_CYC = 16,
  localparam int AZ_W      = $clog2(N_AZ),
  localparam int EL_W      = $clog2(N_EL),
  localparam int N_ANT     = NCOL * NROW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  output logic                     beacon_req,
  output logic [AZ_W-1:0]          az_idx,
  output logic [EL_W-1:0]          el_idx,
  output logic [N_ANT*PH_BITS-1:0] ant_phase,
  output logic                     auth_ready,
  output logic                     auth_start
);

  logic        rst_sync_n;
  scan_state_e st_q;
  logic        step_en;

  beam_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  beam_scan_fsm #(.BEACON_CYC(BEACON_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .state_o   (st_q),
    .step_en_o (step_en),
    .beacon_o  (beacon_req),
    .ready_o   (auth_ready),
    .start_o   (auth_start)
  );

  beam_grid_ctr #(
    .N_AZ   (N_AZ),
    .N_EL   (N_EL),
    .DEF_AZ (DEF_AZ),
    .DEF_EL (DEF_EL)
  ) u_grid (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_en (step_en),
    .az_o    (az_idx),
    .el_o    (el_idx)
  );

  beam_phase_map #(
    .N_AZ     (N_AZ),
    .N_EL     (N_EL),
    .STEP_DEG (STEP_DEG),
    .NCOL     (NCOL),
    .NROW     (NROW),
    .PH_BITS  (PH_BITS),
    .DEF_AZ   (DEF_AZ),
    .DEF_EL   (DEF_EL)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .az_i    (az_idx),
    .el_i    (el_idx),
    .phase_o (ant_phase)
  );

endmodule

// File: rtl/beam_scan_chk.sv
module beam_scan_chk
  import beam_scan_pkg::*;
#(
  parameter int N_AZ    = 5,
  parameter int N_EL    = 5,
  parameter int NCOL    = 2,
  parameter int NROW    = 2,
  parameter int PH_BITS = 3,
  localparam int AZ_W   = $clog2(N_AZ),
  localparam int EL_W   = $clog2(N_EL),
  localparam int N_ANT  = NCOL * NROW
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic [1:0]               cmd_op,
  input scan_state_e              st,
  input logic                     beacon_req,
  input logic [AZ_W-1:0]          az_idx,
  input logic [EL_W-1:0]          el_idx,
  input logic [N_ANT*PH_BITS-1:0] ant_phase,
  input logic                     auth_ready,
  input logic                     auth_start
);

  logic srch, c_next, c_conf, c_start;
  logic [PH_BITS-1:0] ph_c1, ph_r1, ph_d;

  assign srch    = (st == ST_SEARCH);
  assign c_next  = cmd_valid && (cmd_op == 2'(OP_NEXT));
  assign c_conf  = cmd_valid && (cmd_op == 2'(OP_CONFIRM));
  assign c_start = cmd_valid && (cmd_op == 2'(OP_START));
  assign ph_c1   = ant_phase[1*PH_BITS +: PH_BITS];
  assign ph_r1   = ant_phase[NCOL*PH_BITS +: PH_BITS];
  assign ph_d    = ant_phase[(NCOL+1)*PH_BITS +: PH_BITS];

  AST_BEACON_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !beacon_req |=> !beacon_req); // R1

  AST_HOLD_OUTSIDE_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !srch |=> ($stable(az_idx) && $stable(el_idx))); // R8

  AST_AZ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (srch && c_next && (int'(az_idx) != N_AZ-1))
      |=> ((az_idx == $past(az_idx) + 1'b1) && $stable(el_idx))); // R3

  AST_GRID_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (srch && c_next && (int'(az_idx) == N_AZ-1) && (int'(el_idx) == N_EL-1))
      |=> ((az_idx == '0) && (el_idx == '0))); // R4

  AST_PHASE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ph_d == PH_BITS'(ph_c1 + ph_r1)); // R5

  AST_CONFIRM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (srch && c_conf) |=> (auth_ready && $stable(az_idx) && $stable(el_idx))); // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    auth_start |=> (!auth_start && !auth_ready)); // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({beacon_req, auth_ready, auth_start})); // R7

  AST_SEARCH_START_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (srch && c_start) |=> (!auth_start && !auth_ready)); // R9

endmodule

bind beam_scan_ctrl beam_scan_chk #(
  .N_AZ    (N_AZ),
  .N_EL    (N_EL),
  .NCOL    (NCOL),
  .NROW    (NROW),
  .PH_BITS (PH_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .st         (st_q),
  .beacon_req (beacon_req),
  .az_idx     (az_idx),
  .el_idx     (el_idx),
  .ant_phase  (ant_phase),
  .auth_ready (auth_ready),
  .auth_start (auth_start)
);

// File: tb/sim_beam_scan_ctrl.sv
`timescale 1ns/1ps
module sim_beam_scan_ctrl;

  localparam int BCYC = 16;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        beacon_req;
  logic [2:0]  az_idx;
  logic [2:0]  el_idx;
  logic [11:0] ant_phase;
  logic        auth_ready;
  logic        auth_start;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  beam_scan_ctrl #(.BEACON_CYC(BCYC)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .beacon_req (beacon_req),
    .az_idx     (az_idx),
    .el_idx     (el_idx),
    .ant_phase  (ant_phase),
    .auth_ready (auth_ready),
    .auth_start (auth_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_axis(input int idx);
    real a;
    real v;
    int  r;
    a = idx * 45.0 * 3.14159265358979 / 180.0;
    v = -$cos(a) * 8.0;
    r = int'(v);
    return ((r % 8) + 8) % 8;
  endfunction

  function automatic logic [11:0] exp_phase(input int a, input int e);
    logic [11:0] p;
    p = '0;
    for (int k = 0; k < 4; k++) begin
      p[k*3 +: 3] = 3'(((k % 2) * exp_axis(a) + (k / 2) * exp_axis(e)) % 8);
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_dir(input string req, input int a, input int e);
    chk(int'(az_idx) == a, req, int'(az_idx), a);
    chk(int'(el_idx) == e, req, int'(el_idx), e);
    chk(ant_phase == exp_phase(a, e), req, int'(ant_phase), int'(exp_phase(a, e)));
  endtask

  // one-cycle command, then sampled after the phase register has followed
  task automatic send(input logic v, input logic [1:0] op);
    @(negedge clk);
    cmd_valid = v;
    cmd_op    = op;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int a;
    int e;
    int hi;
    bit seen [25];
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state, R1 beacon up during reset
    chk(beacon_req == 1'b1, "R1", int'(beacon_req), 1);
    chk(auth_ready == 1'b0 && auth_start == 1'b0, "R7", int'({auth_ready, auth_start}), 0);
    chk_dir("R2", 0, 2);

    // R1 beacon length, with commands pushed at it
    rst_n = 1'b1;
    hi = 0;
    while (beacon_req && hi < 100) begin
      cmd_valid = 1'b1;
      cmd_op    = (hi % 2 == 0) ? 2'b01 : 2'b10;
      @(posedge clk);
      @(negedge clk);
      if (beacon_req) hi++;
    end
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    chk(hi == BCYC + 1, "R1", hi, BCYC + 1);
    @(posedge clk);
    @(negedge clk);
    chk(auth_ready == 1'b0, "R1", int'(auth_ready), 0);
    chk_dir("R2", 0, 2);

    // R3/R4/R5 exhaustive walk
    a = 0;
    e = 2;
    for (int i = 0; i < 25; i++) seen[i] = 0;
    seen[e*5 + a] = 1;
    for (int s = 0; s < 25; s++) begin
      send(1'b1, 2'b01);
      if (a == 4) begin
        a = 0;
        e = (e == 4) ? 0 : e + 1;
      end else begin
        a++;
      end
      if (s < 24) begin
        chk(!seen[e*5 + a], "R4", e*5 + a, -1);
        seen[e*5 + a] = 1;
      end
      chk_dir((a == 0 && e == 0) ? "R4" : "R3", a, e);
      chk(beacon_req == 1'b0, "R1", int'(beacon_req), 0);
    end
    chk(a == 0 && e == 2, "R4", e*5 + a, 10);

    // R9 strobe low and start-auth in search
    send(1'b0, 2'b01);
    send(1'b0, 2'b10);
    chk_dir("R9", 0, 2);
    send(1'b1, 2'b11);
    chk(auth_start == 1'b0 && auth_ready == 1'b0, "R9", int'({auth_ready, auth_start}), 0);
    chk_dir("R9", 0, 2);

    // move to az 3, el 2 then confirm (R6)
    repeat (3) send(1'b1, 2'b01);
    chk_dir("R3", 3, 2);
    send(1'b1, 2'b10);
    chk(auth_ready == 1'b1, "R6", int'(auth_ready), 1);
    chk_dir("R6", 3, 2);

    // R7 ignored in ready
    send(1'b1, 2'b01);
    send(1'b1, 2'b10);
    chk(auth_ready == 1'b1 && auth_start == 1'b0, "R7", int'({auth_ready, auth_start}), 2);
    chk_dir("R7", 3, 2);

    // R7 start pulse
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'b11;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    chk(auth_start == 1'b1, "R7", int'(auth_start), 1);
    chk(auth_ready == 1'b0, "R7", int'(auth_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(auth_start == 1'b0, "R7", int'(auth_start), 0);

    // R8 locked
    send(1'b1, 2'b01);
    send(1'b1, 2'b10);
    send(1'b1, 2'b11);
    chk(auth_start == 1'b0 && auth_ready == 1'b0, "R8", int'({auth_ready, auth_start}), 0);
    chk_dir("R8", 3, 2);

    // R2 mid-run reset restores beacon and default
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(beacon_req == 1'b1, "R1", int'(beacon_req), 1);
    chk_dir("R2", 0, 2);
    rst_n = 1'b1;
    repeat (BCYC + 4) @(posedge clk);
    @(negedge clk);
    chk(beacon_req == 1'b0, "R1", int'(beacon_req), 0);
    send(1'b1, 2'b01);
    chk_dir("R3", 1, 2);

    finish_run();
  end

endmodule